// File: doc/BRIEF.md
# Class-of-Service Way-Masked Victim Selector

This block works next to a 16-way, 1024-set cache with 64-byte lines (1 MiB in total). On every line fill it chooses the way that receives the new line. Software can fence off part of the cache from replacement, for example to keep a region pinned as scratch memory. The other ways keep normal evicting behaviour. Four capacity masks are stored, one for each class of service, together with a class selector that names the active mask. Each mask bit guards one aligned pair of ways: bit i covers ways 2i and 2i+1, which is 128 KiB of capacity.

For a fill request, the cache presents the set index and that set's 16 valid bits. The block combines these with the set's stored pseudo-LRU tree and returns the victim way one cycle later. Ways outside the active mask never receive a fill, but lines already held there still hit, because hit detection lies outside this block. The cache reports every hit and every fill on a separate touch port, and the block uses these reports to keep its per-set recency trees current.

Top module: `cos_victim_sel`

## Requirements
- R1: After a synchronous active-low reset, all four masks read 0xFF, the selector reads 0, `fill_valid` is 0, every set's recency tree is all zeros, and `cfg_err` is 0.
- R2: A write with `cfg_addr` 0 to 3 loads the mask of that class. A write with address 4 loads the selector. `cfg_rdata` shows the value at `cfg_addr` combinationally: the mask for addresses 0 to 3, and the selector zero-extended for address 4.
- R3: A write of 0x00 to a mask address is refused and the old mask stays in place. In the cycle after the refused write, `cfg_err` is 1. After any other write, or when no write occurs, it is 0.
- R4: `fill_valid` is 1 in exactly the cycle after a cycle with `fill_req` high, and 0 at all other times.
- R5: The returned way w always satisfies active_mask[w/2] = 1. Here active_mask is the mask of the selected class at the time of the request.
- R6: If any allowed way is invalid (its `fill_valid_bits` bit is 0), the lowest-numbered allowed invalid way is returned.
- R7: If every allowed way is valid, a 15-node tree is walked from the root. Node n has children 2n+1 (the lower half of the ways) and 2n+2 (the upper half). At each node the walk goes to the half that is the only one holding allowed ways. If both halves hold allowed ways, it goes upper when the node bit is 1 and lower when it is 0. A touch of way w sets each node on w's path to point away from w: 0 if w lies in the upper half, 1 if it lies in the lower half.
- R8: A selector write takes effect from the next fill request. A fill requested in the same cycle as the selector write still uses the old class.
- R9: Only the low 2 bits of a selector write are stored. Writes to addresses 5 to 7 change nothing, raise no error, and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address: 0-3 masks, 4 selector |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| cfg_err | output | 1 | Pulses 1 the cycle after a refused all-zero mask write |
| fill_req | input | 1 | Victim request |
| fill_set | input | 10 | Set index of the request |
| fill_valid_bits | input | 16 | Valid bit of each way in that set |
| fill_valid | output | 1 | Victim result is present |
| fill_way | output | 4 | Chosen victim way |
| touch_en | input | 1 | Hit or fill report for recency update |
| touch_set | input | 10 | Set of the reported access |
| touch_way | input | 4 | Way of the reported access |

## Verification
The bench targets masks that leave a single way pair allowed, and sets in which the only invalid ways fall outside the mask. A selector that ignored the mask would fill a pinned way in these cases, and an invalid-first search that did not apply the mask would pick a fenced-off empty way. Full sets under sparse masks exercise the tree walk. A walk that followed node bits into a subtree with no allowed ways, or that updated the recency tree with the wrong polarity, would return a way that differs from the bench's prediction. All-zero mask writes, out-of-range addresses and a selector write in the same cycle as a fill check that a refused write leaves the old mask active and that a class change is not applied one request early.

// File: rtl/cos_victim_pkg.sv
// Shared geometry constants for the class-of-service victim selector.
package cos_victim_pkg;
    localparam int WAYS      = 16;
    localparam int SETS      = 1024;
    localparam int MASK_BITS = 8;
    localparam int NUM_CLS   = 4;
endpackage

// File: rtl/cos_mask_regs.sv
// Class mask register file: one capacity mask per class plus a class selector.
// Assumes a single write port; all-zero mask writes are refused and flagged.
module cos_mask_regs #(
    parameter int NUM_CLS   = cos_victim_pkg::NUM_CLS,
    parameter int MASK_BITS = cos_victim_pkg::MASK_BITS,
    parameter int ADDR_W    = 3,
    parameter int CLS_W     = $clog2(NUM_CLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [MASK_BITS-1:0] wdata,
    output logic [MASK_BITS-1:0] rdata,
    output logic                 err,
    output logic [MASK_BITS-1:0] active_mask
);
    logic [NUM_CLS-1:0][MASK_BITS-1:0] masks_q;
    logic [CLS_W-1:0]                  sel_q;
    logic                              is_mask_addr;
    logic                              is_sel_addr;

    assign is_mask_addr = int'(addr) < NUM_CLS;
    assign is_sel_addr  = int'(addr) == NUM_CLS;

    // Register update: masks, selector and the one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masks_q <= {NUM_CLS{{MASK_BITS{1'b1}}}};
            sel_q   <= '0;
            err     <= 1'b0;
        end else begin
            err <= 1'b0;
            if (we && is_mask_addr) begin
                if (wdata == '0) err <= 1'b1;
                else             masks_q[addr[CLS_W-1:0]] <= wdata;
            end else if (we && is_sel_addr) begin
                sel_q <= wdata[CLS_W-1:0];
            end
        end
    end

    // Read mux for the configuration port.
    always_comb begin
        rdata = '0;
        if (is_mask_addr)     rdata = masks_q[addr[CLS_W-1:0]];
        else if (is_sel_addr) rdata = MASK_BITS'(sel_q);
    end

    assign active_mask = masks_q[sel_q];

    // R3: a refused zero write leaves every mask untouched.
    p_zero_keeps_mask_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (we && is_mask_addr && wdata == '0) |=> $stable(masks_q));

    // R3: the active mask never becomes empty.
    p_active_nonzero_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);
endmodule

// File: rtl/cos_plru_store.sv
// Per-set tree pseudo-LRU state. Reads are combinational; touch updates
// rewrite the path of the touched way to point away from it.
// Assumes WAYS is a power of two.
module cos_plru_store #(
    parameter int WAYS   = cos_victim_pkg::WAYS,
    parameter int SETS   = cos_victim_pkg::SETS,
    parameter int SET_W  = $clog2(SETS),
    parameter int WAY_W  = $clog2(WAYS),
    parameter int TREE_N = WAYS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    output logic [TREE_N-1:0] rd_tree,
    input  logic              upd_en,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [WAY_W-1:0]  upd_way
);
    logic [TREE_N-1:0] tree_mem [SETS];
    logic [TREE_N-1:0] upd_tree;

    assign rd_tree = tree_mem[rd_set];

    // Next tree value for the touched set: flip the path away from the way.
    always_comb begin
        int node;
        upd_tree = tree_mem[upd_set];
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            upd_tree[node] = ~upd_way[WAY_W-1-lvl];
            node = 2 * node + 1 + int'(upd_way[WAY_W-1-lvl]);
        end
    end

    // Storage: clear on reset, write back on touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_mem[s] <= '0;
        end else if (upd_en) begin
            tree_mem[upd_set] <= upd_tree;
        end
    end
endmodule

// File: rtl/cos_victim_pick.sv
// Combinational victim choice: lowest allowed invalid way first, else a
// tree walk that never enters a subtree without allowed ways.
// Assumes at least one way is allowed.
module cos_victim_pick #(
    parameter int WAYS   = cos_victim_pkg::WAYS,
    parameter int WAY_W  = $clog2(WAYS),
    parameter int TREE_N = WAYS - 1
) (
    input  logic [WAYS-1:0]   allow,
    input  logic [WAYS-1:0]   valid,
    input  logic [TREE_N-1:0] tree,
    output logic [WAY_W-1:0]  way
);
    localparam int NODES = 2 * WAYS - 1;

    // Subtree reachability, invalid-first search, then the masked tree walk.
    always_comb begin
        logic [NODES-1:0] sub;
        logic [WAYS-1:0]  free;
        int               node;
        int               low_free;
        sub = '0;
        for (int w = 0; w < WAYS; w++) sub[TREE_N + w] = allow[w];
        for (int n = TREE_N - 1; n >= 0; n--) sub[n] = sub[2*n+1] | sub[2*n+2];
        free = allow & ~valid;
        low_free = 0;
        for (int w = WAYS - 1; w >= 0; w--) if (free[w]) low_free = w;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            if (sub[2*node+2] && (!sub[2*node+1] || tree[node])) node = 2 * node + 2;
            else                                                 node = 2 * node + 1;
        end
        if (free != '0) way = WAY_W'(low_free);
        else            way = WAY_W'(node - TREE_N);
        // R5: a chosen way is always an allowed one when any is allowed.
        if (allow != '0) assert (allow[way]);
    end
endmodule

// File: rtl/cos_victim_sel.sv
// Top: class-masked victim selector. Expands the active class mask to ways,
// picks a victim and registers it one cycle after the request.
module cos_victim_sel #(
    parameter int WAYS      = cos_victim_pkg::WAYS,
    parameter int SETS      = cos_victim_pkg::SETS,
    parameter int MASK_BITS = cos_victim_pkg::MASK_BITS,
    parameter int NUM_CLS   = cos_victim_pkg::NUM_CLS,
    parameter int ADDR_W    = $clog2(NUM_CLS + 1),
    parameter int SET_W     = $clog2(SETS),
    parameter int WAY_W     = $clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [MASK_BITS-1:0] cfg_wdata,
    output logic [MASK_BITS-1:0] cfg_rdata,
    output logic                 cfg_err,
    input  logic                 fill_req,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [WAYS-1:0]      fill_valid_bits,
    output logic                 fill_valid,
    output logic [WAY_W-1:0]     fill_way,
    input  logic                 touch_en,
    input  logic [SET_W-1:0]     touch_set,
    input  logic [WAY_W-1:0]     touch_way
);
    localparam int GROUP  = WAYS / MASK_BITS;
    localparam int TREE_N = WAYS - 1;

    logic [MASK_BITS-1:0] active_mask;
    logic [WAYS-1:0]      allow;
    logic [TREE_N-1:0]    set_tree;
    logic [WAY_W-1:0]     pick_way;
    logic [MASK_BITS-1:0] dec_mask_q;
    logic [WAYS-1:0]      dec_valid_q;
    logic                 dec_free_q;

    cos_mask_regs #(.NUM_CLS(NUM_CLS), .MASK_BITS(MASK_BITS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .err(cfg_err), .active_mask(active_mask)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_allow
        assign allow[g] = active_mask[g / GROUP];
    end

    cos_plru_store #(.WAYS(WAYS), .SETS(SETS)) plru_i (
        .clk(clk), .rst_n(rst_n), .rd_set(fill_set), .rd_tree(set_tree),
        .upd_en(touch_en), .upd_set(touch_set), .upd_way(touch_way)
    );

    cos_victim_pick #(.WAYS(WAYS)) pick_i (
        .allow(allow), .valid(fill_valid_bits), .tree(set_tree), .way(pick_way)
    );

    // Result register plus the decision context kept for checking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid  <= 1'b0;
            fill_way    <= '0;
            dec_mask_q  <= '1;
            dec_valid_q <= '0;
            dec_free_q  <= 1'b0;
        end else begin
            fill_valid <= fill_req;
            if (fill_req) begin
                fill_way    <= pick_way;
                dec_mask_q  <= active_mask;
                dec_valid_q <= fill_valid_bits;
                dec_free_q  <= |(allow & ~fill_valid_bits);
            end
        end
    end

    // R4: a result follows every request one cycle later.
    p_result_follows_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && fill_req) |=> fill_valid);
    // R4: no result without a request.
    p_no_spurious_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !fill_req) |=> !fill_valid);
    // R5: the victim lies inside the mask in force at request time.
    p_in_mask_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> dec_mask_q[int'(fill_way) / GROUP]);
    // R6: an empty allowed way beats any occupied one.
    p_invalid_first_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && dec_free_q) |-> !dec_valid_q[fill_way]);
endmodule

// File: tb/cos_victim_sel_tb_top.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module cos_victim_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        cfg_err;
    logic        fill_req = 1'b0;
    logic [9:0]  fill_set = '0;
    logic [15:0] fill_valid_bits = '0;
    logic        fill_valid;
    logic [3:0]  fill_way;
    logic        touch_en = 1'b0;
    logic [9:0]  touch_set = '0;
    logic [3:0]  touch_way = '0;

    int vectors = 0;
    int fails   = 0;

    logic [7:0]  m_mask [4];
    logic [1:0]  m_sel;
    logic [14:0] m_tree [1024];

    always #10 clk = ~clk;

    cos_victim_sel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .fill_req(fill_req), .fill_set(fill_set), .fill_valid_bits(fill_valid_bits),
        .fill_valid(fill_valid), .fill_way(fill_way), .touch_en(touch_en),
        .touch_set(touch_set), .touch_way(touch_way)
    );

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit any_allowed(logic [7:0] mk, int lo, int hi);
        for (int w = lo; w < hi; w++) if (mk[w/2]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int ref_pick(logic [7:0] mk, logic [15:0] vb, logic [14:0] tr);
        int lo = 0, span = 16, node = 0;
        for (int w = 0; w < 16; w++) if (mk[w/2] && !vb[w]) return w;
        while (span > 1) begin
            int half = span / 2;
            bit la = any_allowed(mk, lo, lo + half);
            bit ra = any_allowed(mk, lo + half, lo + span);
            if (ra && (!la || tr[node])) begin lo += half; node = 2*node + 2; end
            else                          node = 2*node + 1;
            span = half;
        end
        return lo;
    endfunction

    task automatic model_touch(int s, int way);
        int lo = 0, span = 16, node = 0;
        while (span > 1) begin
            int half = span / 2;
            bit up = way >= lo + half;
            m_tree[s][node] = !up;
            if (up) begin lo += half; node = 2*node + 2; end
            else      node = 2*node + 1;
            span = half;
        end
    endtask

    task automatic cfg_wr(int a, int d, output bit err);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        err = cfg_err;
        if (a < 4 && d != 0) m_mask[a] = 8'(d);
        if (a == 4) m_sel = 2'(d);
    endtask

    task automatic cfg_rd(int a, output int v);
        cfg_addr = 3'(a);
        #1 v = int'(cfg_rdata);
    endtask

    task automatic do_touch(int s, int way);
        @(negedge clk);
        touch_en = 1'b1; touch_set = 10'(s); touch_way = 4'(way);
        @(negedge clk);
        touch_en = 1'b0;
        model_touch(s, way);
    endtask

    task automatic do_fill(int s, logic [15:0] vb, string req);
        int exp;
        logic [7:0] mk;
        mk  = m_mask[m_sel];
        exp = ref_pick(mk, vb, m_tree[s]);
        @(negedge clk);
        fill_req = 1'b1; fill_set = 10'(s); fill_valid_bits = vb;
        @(negedge clk);
        fill_req = 1'b0;
        chk("R4 fill_valid after request", int'(fill_valid), 1);
        chk("R5 way inside active mask", int'(mk[fill_way/2]), 1);
        chk(req, int'(fill_way), exp);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        int v;
        bit e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_mask[i] = 8'hFF;
        m_sel = 2'd0;
        for (int s = 0; s < 1024; s++) m_tree[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin cfg_rd(a, v); chk("R1 mask after reset", v, 255); end
        cfg_rd(4, v); chk("R1 selector after reset", v, 0);
        chk("R1 fill_valid after reset", int'(fill_valid), 0);
        chk("R1 cfg_err after reset", int'(cfg_err), 0);
        do_fill(5, 16'hFFFF, "R1 R7 cleared tree picks way 0");

        // R2: write and read back
        cfg_wr(1, 8'h0F, e); chk("R3 no error on legal write", int'(e), 0);
        cfg_rd(1, v); chk("R2 mask1 readback", v, 8'h0F);
        cfg_wr(4, 1, e); cfg_rd(4, v); chk("R2 selector readback", v, 1);

        // R3: zero write refused
        cfg_wr(1, 0, e); chk("R3 error pulse", int'(e), 1);
        cfg_rd(1, v); chk("R3 mask kept", v, 8'h0F);
        @(negedge clk); chk("R3 error clears", int'(cfg_err), 0);

        // R6: invalid-first inside the mask; outside invalid ways ignored
        do_fill(3, 16'h0003, "R6 lowest allowed invalid way");
        do_fill(3, 16'hFDFF, "R5 invalid way outside mask skipped");
        @(negedge clk); chk("R4 no result without request", int'(fill_valid), 0);

        // R7: single-pair mask and tree steering
        cfg_wr(1, 8'h40, e);
        do_fill(9, 16'hFFFF, "R7 single pair mask");
        do_touch(9, 12);
        do_fill(9, 16'hFFFF, "R7 walk after touch");
        cfg_wr(1, 8'h81, e);
        do_touch(9, 0);
        do_fill(9, 16'hFFFF, "R7 sparse mask after touch");

        // R8: selector write in the same cycle as a fill uses old class
        cfg_wr(2, 8'h02, e);
        @(negedge clk);
        v = ref_pick(m_mask[m_sel], 16'hFFFF, m_tree[9]);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 8'd2;
        fill_req = 1'b1; fill_set = 10'd9; fill_valid_bits = 16'hFFFF;
        @(negedge clk);
        cfg_we = 1'b0; fill_req = 1'b0; m_sel = 2'd2;
        chk("R8 same-cycle fill uses old class", int'(fill_way), v);
        do_fill(9, 16'hFFFF, "R8 next fill uses new class");

        // R9: selector truncation and unused addresses
        cfg_wr(6, 0, e); chk("R9 unused address no error", int'(e), 0);
        cfg_rd(6, v); chk("R9 unused address reads 0", v, 0);
        cfg_rd(2, v); chk("R9 masks untouched", v, 2);
        cfg_wr(4, 8'hFE, e); cfg_rd(4, v); chk("R9 selector low bits", v, 2);

        // Random traffic
        for (int it = 0; it < 3000; it++) begin
            int op = int'($urandom_range(0, 9));
            int s  = ($urandom_range(0, 8) == 8) ? 1023 : int'($urandom_range(0, 7));
            if (op == 0) begin
                int a = int'($urandom_range(0, 3));
                int d = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(0, 255));
                cfg_wr(a, d, e);
                chk("R3 error flag on random write", int'(e), int'(d == 0));
                cfg_rd(a, v); chk("R2 R3 random mask readback", v, int'(m_mask[a]));
            end else if (op == 1) begin
                cfg_wr(4, int'($urandom_range(0, 255)), e);
            end else if (op <= 4) begin
                do_touch(s, int'($urandom_range(0, 15)));
            end else begin
                logic [15:0] vb;
                vb = ($urandom_range(0, 1) == 0) ? 16'hFFFF
                     : 16'($urandom() | $urandom() | $urandom());
                do_fill(s, vb, "R6 R7 random fill victim");
            end
        end

        report();
        $finish;
    end
endmodule